// File: doc/BRIEF.md
# Periodic Limit Counter Timer

This block is a free-running periodic counter with a 32-bit word register port. A prescaler turns the core clock into one tick every 500 ns. Each tick advances a counter that is compared against a programmable limit. When the next count would reach the limit, the counter returns to zero, a sticky reached flag is set and a level interrupt is raised.

Software programs the period through a limit register, which has two write addresses. One also restarts the count and the other leaves it running. A status word returns the current count together with the reached flag. Reading the limit back acknowledges the interrupt, so a handler can confirm the period and clear the event with one access.

The count is kept in register units: the increment position is bit 9, and bits 8:0 always read as zero. The limit uses the same units. Read data is registered and appears in the cycle after the read strobe.

Top module: `tmr_periodic`

## Requirements
- R1: The count advances by one (bit 9 of the register view) once every PRESCALE core clocks. A read of word 1 returns the count in bits 30:9, with bits 8:0 always zero.
- R2: A limit write keeps only bits 30:9 of the write data. Writing 0x800007FF gives a limit of 0x00000600.
- R3: If the masked limit is zero, the limit becomes 0x7FFFFE00.
- R4: A write to word 0 loads the limit, restarts the count and the prescaler from zero, and drives the interrupt low from the next cycle. The reached flag is left unchanged.
- R5: A write to word 2 loads the limit and leaves the count and the prescaler running. A later wrap uses the new limit.
- R6: A read of word 0 returns the limit in bits 30:9, with bits 31 and 8:0 zero. The same read clears the reached flag and the interrupt, unless a wrap happens in the same cycle, in which case the wrap wins.
- R7: On a tick where count+1 is at least the limit, the count returns to zero, the reached flag (bit 31 of word 1) is set and the interrupt goes high after that edge. This includes a limit that was lowered below the running count.
- R8: The interrupt is a level that stays high through further wraps until a word-0 read or a word-0 write acknowledges it.
- R9: The word index is address bits 4:2, and higher address bits are ignored. Reads of indices other than 0 and 1 return zero. Writes to indices other than 0 and 2 change nothing.
- R10: After reset the limit is 0x7FFFFE00, the count is zero, the reached flag is clear, the counter is running and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address; bits 4:2 select the word |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd and held until the next read |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with PRESCALE set to 4 and ADDR_W set to 8. With this prescale a tick lands every fourth clock, so a three-tick period wraps within a dozen cycles and every tick edge can be predicted exactly from the cycle of the last restart. With an 8-bit address the bench can reach addresses above bit 4 and check that they alias onto the same word. Limits of 2, 3 and 16 ticks put the first wrap, repeated sticky wraps and a limit lowered below the running count all within a few hundred cycles.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int CNT_LSB = 9;
    localparam int CNT_MSB = 30;
    localparam int CW      = CNT_MSB - CNT_LSB + 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] lim;
        logic          reached;
        logic          irq;
        logic [31:0]   rdata;
    } tmr_state_t;

    // Keep bits 30:9; an empty field selects the longest period.
    function automatic logic [CW-1:0] lim_field(input logic [31:0] wdata);
        logic [CW-1:0] f;
        f = wdata[CNT_MSB:CNT_LSB];
        return (f == '0) ? '1 : f;
    endfunction
endpackage

// File: rtl/tmr_tick.sv
module tmr_tick #(
    parameter int PRESCALE = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] pre_d, pre_q;

    assign tick = (pre_q == LAST) && !restart;

    always_comb begin
        pre_d = pre_q;
        if (restart || pre_q == LAST) pre_d = '0;
        else                          pre_d = pre_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/tmr_decode.sv
module tmr_decode #(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output logic              wr_lim_rst,
    output logic              wr_lim_keep,
    output logic              rd_lim,
    output logic              rd_cnt
);
    localparam int IDX_W = 3;
    logic [IDX_W-1:0] idx;

    assign idx         = addr[4:2];
    assign wr_lim_rst  = wr && (idx == 3'd0);
    assign wr_lim_keep = wr && (idx == 3'd2);
    assign rd_lim      = rd && (idx == 3'd0);
    assign rd_cnt      = rd && (idx == 3'd1);
endmodule

// File: rtl/tmr_periodic.sv
module tmr_periodic
    import tmr_pkg::*;
#(
    parameter int PRESCALE = 50,
    parameter int ADDR_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    localparam logic [CNT_LSB-1:0] LOW_ZERO = '0;

    tmr_state_t st_d, st_q;
    logic wr_lim_rst, wr_lim_keep, rd_lim, rd_cnt, tick;
    logic [CW:0] cnt_inc;
    logic wrap;

    tmr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr        (bus_addr),
        .wr          (bus_wr),
        .rd          (bus_rd),
        .wr_lim_rst  (wr_lim_rst),
        .wr_lim_keep (wr_lim_keep),
        .rd_lim      (rd_lim),
        .rd_cnt      (rd_cnt)
    );

    tmr_tick #(.PRESCALE(PRESCALE)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (wr_lim_rst),
        .tick    (tick)
    );

    assign cnt_inc = {1'b0, st_q.cnt} + 1'b1;
    assign wrap    = tick && (cnt_inc >= {1'b0, st_q.lim});

    always_comb begin
        st_d = st_q;
        // acknowledge first so a coincident wrap wins
        if (rd_lim) begin
            st_d.reached = 1'b0;
            st_d.irq     = 1'b0;
        end
        if (wrap) begin
            st_d.cnt     = '0;
            st_d.reached = 1'b1;
            st_d.irq     = 1'b1;
        end else if (tick) begin
            st_d.cnt = cnt_inc[CW-1:0];
        end
        if (wr_lim_keep) st_d.lim = lim_field(bus_wdata);
        if (wr_lim_rst) begin
            st_d.lim = lim_field(bus_wdata);
            st_d.cnt = '0;
            st_d.irq = 1'b0;
        end
        if (bus_rd) begin
            if (rd_lim)      st_d.rdata = {1'b0, st_q.lim, LOW_ZERO};
            else if (rd_cnt) st_d.rdata = {st_q.reached, st_q.cnt, LOW_ZERO};
            else             st_d.rdata = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt     <= '0;
            st_q.lim     <= '1;
            st_q.reached <= 1'b0;
            st_q.irq     <= 1'b0;
            st_q.rdata   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign irq       = st_q.irq;
endmodule

// File: rtl/tmr_periodic_chk.sv
module tmr_periodic_chk
    import tmr_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          wr0,
    input logic          rd0,
    input logic          rd1,
    input logic          rd_any,
    input logic          tick,
    input logic [CW-1:0] cnt_q,
    input logic [CW-1:0] lim_q,
    input logic          irq,
    input logic [31:0]   rdata
);
    assert_cnt_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr0) |=> $stable(cnt_q));

    assert_cnt_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd1 |=> (rdata[CNT_LSB-1:0] == '0));

    assert_lim_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lim_q != '0);

    assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr0 |=> (!irq && cnt_q == '0));

    assert_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0 && !tick) |=> !irq);

    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !rd0 && !wr0) |=> irq);

    assert_unused_rd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_any && !rd0 && !rd1) |=> (rdata == 32'd0));
endmodule

bind tmr_periodic tmr_periodic_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr0    (wr_lim_rst),
    .rd0    (rd_lim),
    .rd1    (rd_cnt),
    .rd_any (bus_rd),
    .tick   (tick),
    .cnt_q  (st_q.cnt),
    .lim_q  (st_q.lim),
    .irq    (irq),
    .rdata  (bus_rdata)
);

// File: tb/tmr_periodic_test.sv
module tmr_periodic_test;
    localparam int PRE = 4;
    localparam int AW  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq;

    int unsigned cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;
    logic fire = 1'b0;
    logic finished = 1'b0;
    int unsigned w0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    tmr_periodic #(.PRESCALE(PRE), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc  <= cyc + 1;
        fire <= bus_rd;
    end

    // monitor: compare read data against the scoreboard
    always @(negedge clk) begin
        if (fire) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if (bus_rdata !== e) begin
                n_bad++;
                $display("FAIL %s: rdata actual %h expected %h", t, bus_rdata, e);
            end
        end
    end

    task automatic chk_irq(input logic e, input string t);
        n_cmp++;
        if (irq !== e) begin
            n_bad++;
            $display("FAIL %s: irq actual %b expected %b", t, irq, e);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string t);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_to(input int unsigned t);
        while (cyc < t) @(negedge clk);
    endtask

    function automatic logic [31:0] cnt_word(input int unsigned org, input int unsigned lim);
        return 32'((((cyc - org) / PRE) % lim) << 9);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        chk_irq(1'b0, "R10 irq in reset");
        rst_n = 1'b1;
        w0 = cyc;
        chk_irq(1'b0, "R10 irq after reset");
        wait_to(w0 + 9);
        rd(8'h04, cnt_word(w0, 32'h3FFFFF), "R10/R1 count after reset");
        rd(8'h00, 32'h7FFFFE00, "R10 reset limit");

        // R2: masked limit of three ticks
        wr(8'h00, 32'h800007FF);
        w0 = cyc;
        rd(8'h00, 32'h00000600, "R2 masked limit");
        wait_to(w0 + 6);
        rd(8'h04, 32'h00000200, "R1 count one tick");
        wait_to(w0 + 11);
        chk_irq(1'b0, "R7 before first wrap");
        @(negedge clk);
        chk_irq(1'b1, "R7 first wrap");
        wait_to(w0 + 13);
        rd(8'h04, 32'h80000000, "R7 reached flag and zero count");
        wait_to(w0 + 30);
        chk_irq(1'b1, "R8 held through wraps");
        rd(8'h00, 32'h00000600, "R6 limit read");
        chk_irq(1'b0, "R6 acknowledge");
        rd(8'h04, 32'h00000200, "R6 reached cleared");
        wait_to(w0 + 37);
        chk_irq(1'b1, "R8 new wrap");

        // R4 and R3
        wr(8'h00, 32'h000001FF);
        w0 = cyc;
        chk_irq(1'b0, "R4 irq cleared by restart");
        rd(8'h04, 32'h80000000, "R4 restart keeps reached");
        rd(8'h00, 32'h7FFFFE00, "R3 zero limit substitution");

        // R5: change limit while counting
        wait_to(w0 + 40);
        wr(8'h08, 32'h00002000);
        rd(8'h04, 32'h00001400, "R5 count not restarted");
        wait_to(w0 + 63);
        chk_irq(1'b0, "R5 before wrap at new limit");
        @(negedge clk);
        chk_irq(1'b1, "R5 wrap at new limit");
        wait_to(w0 + 66);
        rd(8'h04, 32'h80000000, "R7 wrap to zero at new limit");
        wait_to(w0 + 70);
        rd(8'h00, 32'h00002000, "R6 limit read after keep write");

        // R7: lower the limit below the running count
        wait_to(w0 + 104);
        wr(8'h08, 32'h00000400);
        chk_irq(1'b0, "R7 no wrap before tick");
        wait_to(w0 + 107);
        chk_irq(1'b0, "R7 lowered limit pre-tick");
        @(negedge clk);
        chk_irq(1'b1, "R7 lowered limit wraps on tick");
        rd(8'h04, 32'h80000000, "R7 lowered limit count zero");

        // R9: decode, ignored writes and aliasing
        wr(8'h14, 32'h00000600);
        wr(8'h0C, 32'h00000600);
        wr(8'h10, 32'h00000600);
        rd(8'h00, 32'h00000400, "R9 unused writes ignored");
        rd(8'h08, 32'h00000000, "R9 word 2 reads zero");
        rd(8'h0C, 32'h00000000, "R9 word 3 reads zero");
        rd(8'h1C, 32'h00000000, "R9 word 7 reads zero");
        wr(8'h28, 32'h00000600);
        rd(8'h20, 32'h00000600, "R9 upper address bits ignored");
        repeat (2) @(negedge clk);
        finished = 1'b1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (20000) @(posedge clk);
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule